// File: doc/BRIEF.md
# Serial Bus Release and Command Signaling Controller

This block holds the 8-bit control and status register of a two-wire serial bus port, together with the logic behind it. Software uses two self-clearing trigger bits to drive the serial-output latch. One trigger forces the latch high and so signals a bus release. The other forces it low and so signals a command. The same register carries two detection flags that report when another device on the bus has produced a release or a command condition. The top nibble is plain storage that software can read and write, and has no side effect in this block.

The clock and data lines pass through a two-flop synchronizer. A release is a rising edge of the data line while the clock is high. A command is a falling edge of the data line while the clock is high. Each flag can be cleared from several sources: a transfer-start strobe, both enables being low, reset, and, for the command flag, a later release. Software accesses the register with byte writes, with single-bit writes that name a bit index, and with reads.

Top module: `sbus_sig_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the register reads 0x00 and the serial-output latch is 1.
- R2: Writing 1 to bit 0, either by a byte write or by a bit write with index 0 and value 1, sets the latch to 1 at the clock edge that samples the write. Bit 0 always reads 0.
- R3: Writing 1 to bit 1, either by a byte write or by a bit write with index 1 and value 1, clears the latch to 0 at the clock edge that samples the write. Bit 1 always reads 0.
- R4: When a byte write sets bits 0 and 1 together, the latch goes to 1. When neither trigger is written, the latch keeps its value.
- R5: A rising data edge while the clock is high sets bit 2 (release seen). The flag is visible in the read data three clock edges after the input edge is first sampled.
- R6: A falling data edge while the clock is high sets bit 3 (command seen), with the same latency as R5.
- R7: Data edges while the clock is low set neither flag.
- R8: A transfer-start strobe, or both enables low, clears bits 2 and 3 at the next edge. This clear wins over a set in the same cycle, and while both enables are low no flag can set.
- R9: A detected release clears bit 3 at the same edge where it sets bit 2.
- R10: Writes to bits 2 and 3 have no effect. Bits 7..4 store the written value for byte writes and for bit writes with index 4 to 7, and read back unchanged.
- R11: When a byte write and a bit write arrive in the same cycle, only the byte write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr_byte | input | 1 | Byte write strobe |
| csr_wdata | input | 8 | Byte write data |
| csr_wr_bit | input | 1 | Single-bit write strobe |
| csr_bit_idx | input | 3 | Bit index for a single-bit write |
| csr_bit_val | input | 1 | Value for a single-bit write |
| csr_rdata | output | 8 | Register read data |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| xfer_start | input | 1 | Transfer-start strobe |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| so_latch | output | 1 | Serial-output latch |

## Verification
A wrong latch state appears on `so_latch` at the first edge after the faulty write, and the bench compares it against its model on every clock. A flag that sets too early, too late or never differs from the model in `csr_rdata` within the three-edge detection window. A clear that loses a priority contest shows as a flag bit that stays at 1 one edge after the clear. A storage bit or trigger bit with the wrong read-back differs at the next clock after the write.

// File: rtl/sbus_sig_pkg.sv
// Shared constants and types for the serial bus signaling controller.
// Assumes an 8-bit register with a 4-bit storage nibble at the top.
package sbus_sig_pkg;
    localparam int unsigned CSR_W        = 8;
    localparam int unsigned BIDX_W       = $clog2(CSR_W);
    localparam int unsigned POS_RLS_FIRE = 0;
    localparam int unsigned POS_CMD_FIRE = 1;
    localparam int unsigned POS_RLS_SEEN = 2;
    localparam int unsigned POS_CMD_SEEN = 3;
    localparam int unsigned POS_AUX_LO   = 4;
    localparam int unsigned AUX_W        = CSR_W - POS_AUX_LO;

    // Decoded effect of one register write cycle.
    typedef struct packed {
        logic             rls_fire;
        logic             cmd_fire;
        logic             aux_we;
        logic [AUX_W-1:0] aux_next;
    } wr_dec_t;
endpackage

// File: rtl/sbus_sync.sv
// Multi-stage synchronizer for asynchronous bus lines.
// Assumes that the lines idle at RST_VAL and that STAGES is at least 2.
module sbus_sync #(
    parameter int unsigned    WIDTH   = 2,
    parameter int unsigned    STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage captures the raw line value.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= RST_VAL;
                    else        stg[0] <= d;
                end
            end else begin : g_next
                // Later stages shift the value along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sbus_cond_detect.sv
// Finds release and command conditions on the synchronized bus lines.
// Release is a data rise while clock is high; command is a data fall
// while clock is high. Assumes that the inputs are already synchronized.
module sbus_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic rel_evt,
    output logic cmd_evt
);
    logic sda_prev;

    // Keep the previous data value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_s;
    end

    // Classify the data edges that happen while the clock is high.
    always_comb begin
        rel_evt = scl_s &&  sda_s && !sda_prev;
        cmd_evt = scl_s && !sda_s &&  sda_prev;
    end

    p_rel_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_evt |=> $past(sda_s) && !$past(sda_s, 2) || !$past(rst_n, 2))
        else $error("release without a data rise");
    p_cmd_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_evt |=> !$past(sda_s))
        else $error("command without a data fall");
endmodule

// File: rtl/sbus_flags.sv
// Detection flags for release and command conditions.
// A clear outranks any set. A release also clears the command flag.
module sbus_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_evt,
    input  logic cmd_evt,
    input  logic xfer_start,
    input  logic tx_en,
    input  logic rx_en,
    output logic rls_seen,
    output logic cmd_seen
);
    logic clr_all;

    // A transfer start, or both enables off, wipes both flags.
    always_comb clr_all = xfer_start || (!tx_en && !rx_en);

    // Release flag: clear outranks set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) rls_seen <= 1'b0;
        else if (rel_evt)      rls_seen <= 1'b1;
    end

    // Command flag: clear and a release both outrank set.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all || rel_evt) cmd_seen <= 1'b0;
        else if (cmd_evt)                 cmd_seen <= 1'b1;
    end

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start || (!tx_en && !rx_en)) |=> (!rls_seen && !cmd_seen))
        else $error("flag survived a clear");
    p_rel_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_evt && !xfer_start && (tx_en || rx_en)) |=> rls_seen)
        else $error("release not flagged");
    p_cmd_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_evt && !rel_evt && !xfer_start && (tx_en || rx_en)) |=> cmd_seen)
        else $error("command not flagged");
    p_rel_drops_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rel_evt |=> !cmd_seen)
        else $error("command flag kept after release");
endmodule

// File: rtl/sbus_csr.sv
// Write decode, storage nibble and serial-output latch.
// A byte write outranks a bit write. The trigger bits are not stored;
// they only act on the latch at the edge that samples the write.
module sbus_csr
    import sbus_sig_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_byte,
    input  logic [CSR_W-1:0]  wdata,
    input  logic              wr_bit,
    input  logic [BIDX_W-1:0] bit_idx,
    input  logic              bit_val,
    output logic [AUX_W-1:0]  aux,
    output logic              so_latch
);
    wr_dec_t dec;

    // Turn either write form into trigger pulses and storage updates.
    always_comb begin
        dec          = '0;
        dec.aux_next = aux;
        if (wr_byte) begin
            dec.rls_fire = wdata[POS_RLS_FIRE];
            dec.cmd_fire = wdata[POS_CMD_FIRE];
            dec.aux_we   = 1'b1;
            dec.aux_next = wdata[CSR_W-1:POS_AUX_LO];
        end else if (wr_bit) begin
            if (bit_idx == BIDX_W'(POS_RLS_FIRE)) dec.rls_fire = bit_val;
            if (bit_idx == BIDX_W'(POS_CMD_FIRE)) dec.cmd_fire = bit_val;
            if (bit_idx >= BIDX_W'(POS_AUX_LO)) begin
                dec.aux_we = 1'b1;
                dec.aux_next[bit_idx - BIDX_W'(POS_AUX_LO)] = bit_val;
            end
        end
    end

    // Storage nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)          aux <= '0;
        else if (dec.aux_we) aux <= dec.aux_next;
    end

    // Output latch: release trigger outranks command trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)            so_latch <= 1'b1;
        else if (dec.rls_fire) so_latch <= 1'b1;
        else if (dec.cmd_fire) so_latch <= 1'b0;
    end

    p_rel_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte && wdata[POS_RLS_FIRE]) |=> so_latch)
        else $error("release trigger did not raise latch");
    p_cmd_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte && wdata[POS_CMD_FIRE] && !wdata[POS_RLS_FIRE]) |=> !so_latch)
        else $error("command trigger did not drop latch");
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_byte && !wr_bit) |=> $stable(so_latch))
        else $error("latch moved without a write");
    p_byte_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte && wr_bit) |=> aux == $past(wdata[CSR_W-1:POS_AUX_LO]))
        else $error("bit write overrode byte write");
endmodule

// File: rtl/sbus_sig_ctrl.sv
// Top of the serial bus release/command signaling controller.
// Register image: [7:4] storage, [3] command seen, [2] release seen,
// [1] command trigger (reads 0), [0] release trigger (reads 0).
// Assumes that scl_in and sda_in are asynchronous to clk.
module sbus_sig_ctrl
    import sbus_sig_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr_byte,
    input  logic [CSR_W-1:0]  csr_wdata,
    input  logic              csr_wr_bit,
    input  logic [BIDX_W-1:0] csr_bit_idx,
    input  logic              csr_bit_val,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              xfer_start,
    input  logic              tx_en,
    input  logic              rx_en,
    output logic              so_latch
);
    logic [1:0]       line_s;
    logic             rel_evt, cmd_evt;
    logic             rls_seen, cmd_seen;
    logic [AUX_W-1:0] aux;

    sbus_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(line_s)
    );

    sbus_cond_detect u_det (
        .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]),
        .rel_evt(rel_evt), .cmd_evt(cmd_evt)
    );

    sbus_flags u_flags (
        .clk(clk), .rst_n(rst_n), .rel_evt(rel_evt), .cmd_evt(cmd_evt),
        .xfer_start(xfer_start), .tx_en(tx_en), .rx_en(rx_en),
        .rls_seen(rls_seen), .cmd_seen(cmd_seen)
    );

    sbus_csr u_csr (
        .clk(clk), .rst_n(rst_n), .wr_byte(csr_wr_byte), .wdata(csr_wdata),
        .wr_bit(csr_wr_bit), .bit_idx(csr_bit_idx), .bit_val(csr_bit_val),
        .aux(aux), .so_latch(so_latch)
    );

    // Assemble the read image; trigger positions always read 0.
    always_comb begin
        csr_rdata                          = '0;
        csr_rdata[CSR_W-1:POS_AUX_LO]      = aux;
        csr_rdata[POS_CMD_SEEN]            = cmd_seen;
        csr_rdata[POS_RLS_SEEN]            = rls_seen;
    end

    p_no_both_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_rdata[POS_CMD_SEEN] && rel_evt) |-> 1'b1 ##1 !(rls_seen && cmd_seen && $past(rel_evt)))
        else $error("both flags after a release");
endmodule

// File: tb/sbus_sig_ctrl_test.sv
module sbus_sig_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       csr_wr_byte = 1'b0;
    logic [7:0] csr_wdata = '0;
    logic       csr_wr_bit = 1'b0;
    logic [2:0] csr_bit_idx = '0;
    logic       csr_bit_val = 1'b0;
    logic [7:0] csr_rdata;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       xfer_start = 1'b0;
    logic       tx_en = 1'b1;
    logic       rx_en = 1'b0;
    logic       so_latch;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    string tag = "R1";

    // Reference model state.
    bit [3:0] m_aux;
    bit       m_rls, m_cmd, m_latch;
    bit       h_sda [3];
    bit       h_scl [3];

    sbus_sig_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model update at each edge, then compare shortly after the edge.
    always @(posedge clk) begin
        bit rel, cmd, clr, rf, cf;
        cycles++;
        if (!rst_n) begin
            m_aux = '0; m_rls = 0; m_cmd = 0; m_latch = 1;
            for (int i = 0; i < 3; i++) begin h_sda[i] = 1; h_scl[i] = 1; end
        end else begin
            rel = h_scl[1] && h_sda[1] && !h_sda[2];
            cmd = h_scl[1] && !h_sda[1] && h_sda[2];
            clr = xfer_start || (!tx_en && !rx_en);
            if (clr) begin m_rls = 0; m_cmd = 0; end
            else if (rel) begin m_rls = 1; m_cmd = 0; end
            else if (cmd) m_cmd = 1;
            rf = 0; cf = 0;
            if (csr_wr_byte) begin
                m_aux = csr_wdata[7:4]; rf = csr_wdata[0]; cf = csr_wdata[1];
            end else if (csr_wr_bit) begin
                if (csr_bit_idx == 0) rf = csr_bit_val;
                else if (csr_bit_idx == 1) cf = csr_bit_val;
                else if (csr_bit_idx >= 4) m_aux[csr_bit_idx-4] = csr_bit_val;
            end
            if (rf) m_latch = 1; else if (cf) m_latch = 0;
            h_sda[2] = h_sda[1]; h_sda[1] = h_sda[0]; h_sda[0] = sda_in;
            h_scl[2] = h_scl[1]; h_scl[1] = h_scl[0]; h_scl[0] = scl_in;
        end
        #2;
        check8(csr_rdata, {m_aux, m_cmd, m_rls, 2'b00}, "rdata");
        check8({7'd0, so_latch}, {7'd0, m_latch}, "latch");
        if (cycles > WATCHDOG) begin
            bad++; total++;
            $display("FAIL watchdog %s actual=%0d expected<=%0d", tag, cycles, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); csr_wr_byte = 1; csr_wdata = d;
        @(negedge clk); csr_wr_byte = 0;
    endtask

    task automatic wr_bit(input logic [2:0] idx, input logic v);
        @(negedge clk); csr_wr_bit = 1; csr_bit_idx = idx; csr_bit_val = v;
        @(negedge clk); csr_wr_bit = 0;
    endtask

    task automatic lines(input logic c, input logic d, input int hold);
        @(negedge clk); scl_in = c; sda_in = d;
        idle(hold);
    endtask

    initial begin
        tag = "R1"; idle(3); rst_n = 1; idle(2);
        tag = "R3"; wr_byte(8'h02); idle(1); wr_byte(8'h01); wr_bit(3'd1, 1'b1); idle(1);
        tag = "R2"; wr_byte(8'h01); idle(1); wr_byte(8'h02); wr_bit(3'd0, 1'b1); wr_bit(3'd0, 1'b0); idle(1);
        tag = "R4"; wr_byte(8'h02); wr_byte(8'h03); idle(1); wr_byte(8'h02); idle(3);
        tag = "R6"; lines(1, 1, 3); lines(1, 0, 5);
        tag = "R9"; lines(1, 1, 5);
        tag = "R8"; @(negedge clk); xfer_start = 1; @(negedge clk); xfer_start = 0; idle(2);
        tag = "R7"; lines(0, 1, 2); lines(0, 0, 3); lines(0, 1, 3); lines(1, 1, 3);
        tag = "R5"; lines(0, 0, 2); lines(1, 0, 3); lines(1, 1, 5);
        tag = "R8"; lines(1, 0, 1); xfer_start = 1; idle(4); xfer_start = 0; idle(2);
        lines(1, 1, 1); tx_en = 0; idle(5); lines(1, 0, 5); tx_en = 1; idle(2);
        rx_en = 1; tx_en = 0; lines(1, 1, 5); rx_en = 0; tx_en = 1; idle(2);
        tag = "R10"; wr_byte(8'hFC); wr_bit(3'd5, 1'b0); wr_bit(3'd2, 1'b1);
        wr_bit(3'd3, 1'b1); wr_bit(3'd7, 1'b0); wr_bit(3'd4, 1'b1); idle(2);
        tag = "R11"; @(negedge clk); csr_wr_byte = 1; csr_wdata = 8'h50;
        csr_wr_bit = 1; csr_bit_idx = 3'd7; csr_bit_val = 1;
        @(negedge clk); csr_wr_byte = 0; csr_wr_bit = 0; idle(2);
        tag = "R1"; @(negedge clk); rst_n = 0; idle(2); rst_n = 1; idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule